// File: doc/BRIEF.md
# Cascadable Frame-Checked Serial Slave

This block is the serial front end of a four-channel load driver. A host
microcontroller selects it with an active-low select line and clocks a 16-bit
frame through it. While the host clocks, the block returns a 16-bit status
word that it captures when select falls. At the same time it collects four
4-bit duty codes from the host. When select is released, the collected word
is written into the duty registers. The write happens only when the number of
serial clocks in the frame is a nonzero multiple of 16. Any other count leaves
the previous duty values untouched.

Each bit received on the data input moves through the shift path and leaves on
the data output 16 clocks later. Two blocks can therefore be wired in series
to form one 32-bit link that serves eight loads. All serial inputs are
oversampled by the system clock through a two-stage synchronizer, and their
edges are detected in the system clock domain. The data output is released to
high impedance whenever the block is not selected.

Top module: `cascade_frame_slave`

## Requirements
- R1: `ser_dout` is high impedance while the synchronized select is high and is driven (0 or 1) while it is low.
- R2: On the falling edge of select, `status_i` is captured. `ser_dout` drives 0 until the first rising serial-clock edge. At rising edge k (k = 1..16) it shows status bit 16-k, so the most significant bit comes first.
- R3: `ser_din` is sampled on each falling serial-clock edge. The bit sampled at falling edge k appears on `ser_dout` at rising edge k+16.
- R4: On the rising edge of select after exactly 16 serial clocks, `duty_o` takes the received word. The first bit received lands in bit 15 and the last in bit 0.
- R5: Channel c (c = 1..4) reads its duty code from `duty_o[4c-1:4c-4]`, with its least significant bit at the lower position.
- R6: A frame of 32 or 48 clocks commits the last 16 bits received, in the same order as in R4.
- R7: A frame whose clock count is zero or not a multiple of 16 leaves `duty_o` unchanged.
- R8: The clock count restarts at every falling edge of select. A 5-clock frame followed by an 11-clock frame commits nothing.
- R9: Changes of `status_i` after select has fallen do not alter the bits shifted out in that frame.
- R10: During reset `duty_o` is 0 and `ser_dout` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Active-low frame select from the host |
| ser_clk | input | 1 | Serial clock from the host, idle low |
| ser_din | input | 1 | Serial data from the host or from the previous device in a chain |
| ser_dout | output | 1 | Serial data out; high impedance when not selected |
| status_i | input | 16 | Status word sent back in each frame |
| duty_o | output | 16 | Committed duty codes, four 4-bit channels |

## Verification
A wrong shift position or a lost load shows on `ser_dout` at the first rising serial edge of the next frame. A corrupted LSB capture shows on `ser_dout` sixteen clocks after that bit came in, when the bit passes through. A miscounted frame or a wrong commit condition shows on `duty_o` within a few system cycles of select rising. The commit is either missing, or it happens for a count that should have been rejected. The bench sweeps every frame length from 0 to 48 clocks with a distinct data and status pattern for each, so any off-by-one in the count or the shift is caught.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
   localparam int DEF_CHAN_N  = 4;
   localparam int DEF_CODE_W  = 4;
   localparam int DEF_WORD_W  = DEF_CHAN_N * DEF_CODE_W;
   localparam int DEF_STAGES  = 2;

   typedef struct packed {
      logic sel_fall;   // frame starts
      logic sel_rise;   // frame ends
      logic sck_rise;   // output shift point
      logic sck_fall;   // input sample point
   } edge_t;
endpackage

// File: rtl/fsl_sync.sv
module fsl_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fsl_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fsl_edge_det.sv
module fsl_edge_det
   import fsl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sel_n_s,
   input  logic  sck_s,
   output logic  sel_act,
   output edge_t edges
);
   logic sel_act_q;
   logic sck_q;

   assign sel_act = !sel_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_act_q <= 1'b0;
         sck_q     <= 1'b0;
      end else begin
         sel_act_q <= sel_act;
         sck_q     <= sck_s;
      end
   end

   always_comb begin
      edges.sel_fall = sel_act && !sel_act_q;
      edges.sel_rise = !sel_act && sel_act_q;
      edges.sck_rise = sel_act && sck_s && !sck_q;
      edges.sck_fall = sel_act && !sck_s && sck_q;
   end
endmodule

// File: rtl/fsl_frame_cnt.sv
module fsl_frame_cnt #(
   parameter int WORD_W = 16,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             seen,
   output logic             frame_ok
);
   if ((1 << CNT_W) != WORD_W) begin : g_bad_word
      $error("fsl_frame_cnt: WORD_W must be a power of two");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         seen <= 1'b0;
      end else if (clr) begin
         cnt  <= '0;
         seen <= 1'b0;
      end else if (tick) begin
         cnt  <= cnt + 1'b1;   // wraps at WORD_W
         seen <= 1'b1;
      end
   end

   assign frame_ok = seen && (cnt == '0);
endmodule

// File: rtl/fsl_shifter.sv
module fsl_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              rise,
   input  logic              fall,
   input  logic              din,
   output logic [WORD_W-1:0] word,
   output logic              out_bit
);
   if (WORD_W < 2) begin : g_bad_w
      $error("fsl_shifter: WORD_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word    <= '0;
         out_bit <= 1'b0;
      end else if (load) begin
         word    <= load_word;
         out_bit <= 1'b0;
      end else if (rise) begin
         out_bit <= word[WORD_W-1];
         word    <= {word[WORD_W-2:0], 1'b0};
      end else if (fall) begin
         word[0] <= din;
      end
   end
endmodule

// File: rtl/fsl_duty_bank.sv
module fsl_duty_bank #(
   parameter int CHAN_N = 4,
   parameter int CODE_W = 4,
   localparam int WORD_W = CHAN_N * CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [WORD_W-1:0] word,
   output logic [WORD_W-1:0] duty
);
   for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
      logic [CODE_W-1:0] code_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  code_q <= '0;
         else if (we) code_q <= word[c*CODE_W +: CODE_W];
      end
      assign duty[c*CODE_W +: CODE_W] = code_q;
   end
endmodule

// File: rtl/cascade_frame_slave.sv
module cascade_frame_slave
   import fsl_pkg::*;
#(
   parameter int CHAN_N = DEF_CHAN_N,
   parameter int CODE_W = DEF_CODE_W,
   parameter int STAGES = DEF_STAGES,
   localparam int WORD_W = CHAN_N * CODE_W,
   localparam int CNT_W  = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_sel_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   output logic              ser_dout,
   input  logic [WORD_W-1:0] status_i,
   output logic [WORD_W-1:0] duty_o
);
   if (CHAN_N < 1 || CODE_W < 1) begin : g_bad_cfg
      $error("cascade_frame_slave: CHAN_N and CODE_W must be positive");
   end

   // synchronized serial lines: {select_n, clock, data}
   logic [2:0] ser_s;
   fsl_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_sel_n, ser_clk, ser_din}),
      .q    (ser_s)
   );

   logic  sel_act;
   edge_t edges;
   fsl_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_n_s(ser_s[2]),
      .sck_s  (ser_s[1]),
      .sel_act(sel_act),
      .edges  (edges)
   );

   logic [CNT_W-1:0] cnt;
   logic             seen;
   logic             frame_ok;
   fsl_frame_cnt #(.WORD_W(WORD_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (edges.sel_fall),
      .tick    (edges.sck_fall),
      .cnt     (cnt),
      .seen    (seen),
      .frame_ok(frame_ok)
   );

   logic [WORD_W-1:0] shreg;
   logic              out_bit;
   fsl_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (edges.sel_fall),
      .load_word(status_i),
      .rise     (edges.sck_rise),
      .fall     (edges.sck_fall),
      .din      (ser_s[0]),
      .word     (shreg),
      .out_bit  (out_bit)
   );

   logic commit_p;
   assign commit_p = edges.sel_rise && frame_ok;

   fsl_duty_bank #(.CHAN_N(CHAN_N), .CODE_W(CODE_W)) u_duty (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (commit_p),
      .word (shreg),
      .duty (duty_o)
   );

   assign ser_dout = sel_act ? out_bit : 1'bz;
endmodule

// File: rtl/fsl_chk.sv
module fsl_chk #(
   parameter int WORD_W = 16,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel_fall,
   input logic              sck_rise,
   input logic              commit_p,
   input logic [WORD_W-1:0] status_i,
   input logic [WORD_W-1:0] shreg,
   input logic              out_bit,
   input logic [CNT_W-1:0]  cnt,
   input logic              seen,
   input logic [WORD_W-1:0] duty_o
);
   p_load_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fall |=> (shreg == $past(status_i)) && !out_bit);

   p_shift_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_rise && !sel_fall) |=> out_bit == $past(shreg[WORD_W-1]));

   p_commit_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_p |=> duty_o == $past(shreg));

   p_hold_duty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(duty_o) |-> $past(commit_p));

   p_count_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fall |=> (cnt == '0) && !seen);
endmodule

bind cascade_frame_slave fsl_chk #(.WORD_W(WORD_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel_fall(edges.sel_fall),
   .sck_rise(edges.sck_rise),
   .commit_p(commit_p),
   .status_i(status_i),
   .shreg   (shreg),
   .out_bit (out_bit),
   .cnt     (cnt),
   .seen    (seen),
   .duty_o  (duty_o)
);

// File: tb/sim_cascade_frame_slave.sv
module sim_cascade_frame_slave;
   localparam int H = 6;   // system cycles per serial half period

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sel_n;
   logic        sck;
   logic        din;
   wire         dout;
   logic [15:0] status;
   logic [15:0] duty;
   int          errs = 0;
   int          checks = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cascade_frame_slave u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_sel_n(sel_n),
      .ser_clk  (sck),
      .ser_din  (din),
      .ser_dout (dout),
      .status_i (status),
      .duty_o   (duty)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one frame of n clocks; tx bits leave MSB first from tx[n-1]
   task automatic frame(input int n, input logic [63:0] tx,
                        input int mid_at, input logic [15:0] st_mid,
                        output logic [63:0] rx, output bit pre_ok,
                        output bit drv_ok);
      rx = '0;
      drv_ok = 1'b1;
      sel_n = 1'b0;
      wt(H);
      pre_ok = (dout === 1'b0);
      for (int k = 0; k < n; k++) begin
         sck = 1'b1;
         din = tx[n-1-k];
         wt(H);
         rx[n-1-k] = dout;
         if (dout !== 1'b0 && dout !== 1'b1) drv_ok = 1'b0;
         if (k == mid_at) status = st_mid;
         sck = 1'b0;
         wt(H);
      end
      sel_n = 1'b1;
      wt(H);
   endtask

   function automatic logic [63:0] exp_rx(input int n, input logic [15:0] st,
                                          input logic [63:0] tx);
      logic [63:0] e;
      e = '0;
      for (int k = 0; k < n; k++)
         e[n-1-k] = (k < 16) ? st[15-k] : tx[n-1-(k-16)];
      return e;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [63:0] rx;
      logic [63:0] tx;
      logic [15:0] st;
      logic [15:0] exp_duty;
      bit          pre_ok;
      bit          drv_ok;

      rst_n = 1'b0;
      sel_n = 1'b1;
      sck = 1'b0;
      din = 1'b0;
      status = 16'hA5C3;
      wt(5);
      chk(duty == 16'h0, "R10 duty in reset", 64'(duty), 64'h0);
      chk(dout === 1'bz, "R10 dout hi-z in reset", 64'(dout), 64'h0);
      rst_n = 1'b1;
      wt(4);

      // sweep every frame length 0..48
      exp_duty = 16'h0;
      for (int n = 0; n <= 48; n++) begin
         tx = 64'hD1B5_4A32_D192_ED03 ^ (64'(n) * 64'h9E37_79B9_7F4A_7C15);
         st = 16'h1234 + 16'(n) * 16'h0F1D;
         status = st;
         wt(2);
         frame(n, tx, -1, st, rx, pre_ok, drv_ok);
         chk(pre_ok, "R2 zero before first rise", 64'(dout), 64'h0);
         chk(drv_ok, "R1 driven while selected", 64'(n), 64'h0);
         chk(rx == exp_rx(n, st, tx), (n <= 16) ? "R2 status out" : "R3 passthrough",
             rx, exp_rx(n, st, tx));
         if (n > 0 && n % 16 == 0) begin
            exp_duty = tx[15:0];
            chk(duty == exp_duty, (n == 16) ? "R4 commit" : "R6 multi commit",
                64'(duty), 64'(exp_duty));
         end else begin
            chk(duty == exp_duty, "R7 reject", 64'(duty), 64'(exp_duty));
         end
         chk(dout === 1'bz, "R1 hi-z when deselected", 64'(dout), 64'h0);
      end

      // channel layout: ch1=3, ch2=A, ch3=5, ch4=C
      frame(16, 64'h0000_0000_0000_C5A3, -1, status, rx, pre_ok, drv_ok);
      chk(duty[3:0] == 4'h3, "R5 ch1 field", 64'(duty[3:0]), 64'h3);
      chk(duty[7:4] == 4'hA, "R5 ch2 field", 64'(duty[7:4]), 64'hA);
      chk(duty[11:8] == 4'h5, "R5 ch3 field", 64'(duty[11:8]), 64'h5);
      chk(duty[15:12] == 4'hC, "R5 ch4 field", 64'(duty[15:12]), 64'hC);

      // count restart: 5 then 11 must not combine
      frame(5, 64'h1F, -1, status, rx, pre_ok, drv_ok);
      frame(11, 64'h7FF, -1, status, rx, pre_ok, drv_ok);
      chk(duty == 16'hC5A3, "R8 count restart", 64'(duty), 64'hC5A3);

      // status change after select fell has no effect in that frame
      status = 16'h6E91;
      wt(2);
      frame(16, 64'h0000_0000_0000_2468, 2, 16'h0000, rx, pre_ok, drv_ok);
      chk(rx[15:0] == 16'h6E91, "R9 status captured", rx, 64'h6E91);
      chk(duty == 16'h2468, "R9 commit follows", 64'(duty), 64'h2468);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule